// File: doc/BRIEF.md
# Scatter-List Descriptor Chain Builder

This block turns a scatter list into a linked chain of transfer descriptors for a DMA engine. Software or a sequencer pulses `start` with a total byte count and the base address of the descriptor table. The block then pulls scatter segments, one at a time, over a valid/ready stream. Each segment is an address and a length. The block cuts each segment into chunks no larger than `MAX_CHUNK` bytes and writes one descriptor per chunk into the descriptor memory through a simple word-write port.

Each descriptor takes four consecutive 32-bit words. Its flag word depends on where the descriptor sits in the chain. Its next pointer is computed from the table base, so the chain can be walked in place. When the byte count runs out, the block pulses `done` and presents the number of descriptors it wrote. If the table fills while bytes remain, it pulses `error` instead, so the transfer must not be launched.

Top module: `desc_chain_gen`

## Requirements
- R1: After reset, `busy`, `done`, `error`, `seg_ready` and `wr_en` are all low.
- R2: No descriptor has a buffer size above `MAX_CHUNK`. A segment is split into consecutive chunks, and each chunk's buffer address equals the segment address plus the bytes already taken from that segment.
- R3: The bytes taken from a segment are the smaller of the segment length and the bytes still remaining. A segment that contributes zero bytes produces no descriptor.
- R4: Every descriptor's config word has bit 31 (owned by hardware) and bit 4 (chained) set.
- R5: Config bit 3 (first descriptor) is set in descriptor 0 only.
- R6: The descriptor that brings the remaining count to zero has config bit 2 (last) and bit 5 (end of ring) set, bit 1 clear, and a next pointer of zero.
- R7: Every other descriptor has config bit 1 (suppress completion interrupt) set, bits 2 and 5 clear, and a next pointer of `table_base + (i+1)*16`, computed modulo 2^32.
- R8: Descriptor i occupies word addresses 4i..4i+3. Those words hold the config word, the buffer size, the buffer address and the next pointer, in that order. Exactly four writes are made per descriptor and no others.
- R9: On normal completion, `done` is high for exactly one cycle, `error` stays low, and `desc_count` equals the number of descriptors written.
- R10: If `NUM_DESC` descriptors have been written and bytes still remain, `error` is high for one cycle, `done` stays low, `desc_count` equals `NUM_DESC`, and no further words are written. If the last descriptor exactly uses up the byte count, the block completes normally.
- R11: A start with a total length of zero writes nothing, accepts no segment, and pulses `done` with `desc_count` 0 in the cycle after the start.
- R12: After `done` or `error`, the block is idle. A `start` pulse while `busy` is high is ignored and does not change the chain being built.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin building a chain (honoured only while idle) |
| total_len | input | LEN_W | Total transfer byte count |
| table_base | input | 32 | Byte address of descriptor 0 in the table |
| seg_valid | input | 1 | Scatter segment available |
| seg_ready | output | 1 | Block accepts a segment |
| seg_addr | input | 32 | Segment start address |
| seg_len | input | LEN_W | Segment length in bytes |
| wr_en | output | 1 | Descriptor memory word write |
| wr_addr | output | IDX_W+2 | Word index in the descriptor table |
| wr_data | output | 32 | Word written |
| busy | output | 1 | Chain build in progress |
| done | output | 1 | One-cycle pulse: chain complete |
| error | output | 1 | One-cycle pulse: table overflow |
| desc_count | output | IDX_W+1 | Descriptors written in the last run |

## Verification
The bench builds the block with `NUM_DESC` = 4, `MAX_CHUNK` = 16 and `LEN_W` = 12. With these values, table overflow, an exact fill of the last entry, multi-chunk splits and zero-length segments all appear within runs of a few dozen cycles. The bench sweeps every total from 0 up to the sum of each scatter list, for several lists and table bases, including a base that wraps the 32-bit next pointer. It rebuilds the expected chain arithmetically and compares it word by word against a memory it captures from the write port.

// File: rtl/desc_chain_pkg.sv
package desc_chain_pkg;

  localparam int unsigned WORDS_PER_DESC = 4;
  localparam int unsigned DESC_BYTES     = 16;

  // config word bit positions
  localparam int unsigned FLG_NOIRQ    = 1;
  localparam int unsigned FLG_LAST     = 2;
  localparam int unsigned FLG_FIRST    = 3;
  localparam int unsigned FLG_CHAIN    = 4;
  localparam int unsigned FLG_RING_END = 5;
  localparam int unsigned FLG_HW_OWN   = 31;

  typedef enum logic [1:0] {
    DCG_IDLE  = 2'd0,
    DCG_FETCH = 2'd1,
    DCG_EMIT  = 2'd2
  } dcg_state_e;

  typedef enum logic [1:0] {
    W_CFG  = 2'd0,
    W_SIZE = 2'd1,
    W_ADDR = 2'd2,
    W_NEXT = 2'd3
  } dcg_word_e;

  // flag word from the descriptor's position in the chain
  function automatic logic [31:0] dcg_cfg(input logic first, input logic last);
    logic [31:0] v;
    v = '0;
    v[FLG_HW_OWN] = 1'b1;
    v[FLG_CHAIN]  = 1'b1;
    v[FLG_FIRST]  = first;
    if (last) begin
      v[FLG_LAST]     = 1'b1;
      v[FLG_RING_END] = 1'b1;
    end else begin
      v[FLG_NOIRQ] = 1'b1;
    end
    return v;
  endfunction

  // link to the following table slot, or zero at the end of the chain
  function automatic logic [31:0] dcg_next(input logic [31:0] base,
                                           input logic [31:0] idx,
                                           input logic        last);
    if (last) return 32'd0;
    return base + (idx + 32'd1) * 32'(DESC_BYTES);
  endfunction

endpackage

// File: rtl/dcg_seg_slicer.sv
module dcg_seg_slicer #(
  parameter int unsigned LEN_W     = 24,
  parameter int unsigned MAX_CHUNK = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             advance,
  input  logic [31:0]      seg_addr,
  input  logic [LEN_W-1:0] seg_len,
  input  logic [LEN_W-1:0] remain,
  output logic [LEN_W-1:0] chunk_len,
  output logic [31:0]      chunk_addr,
  output logic             seg_empty
);

  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_CHUNK);

  function automatic logic [LEN_W-1:0] pick_min(input logic [LEN_W-1:0] a,
                                                input logic [LEN_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  logic [31:0]      base_q;
  logic [31:0]      off_q;
  logic [LEN_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      off_q  <= '0;
      left_q <= '0;
    end else if (load) begin
      base_q <= seg_addr;
      off_q  <= '0;
      left_q <= pick_min(seg_len, remain);
    end else if (advance) begin
      off_q  <= off_q + 32'(chunk_len);
      left_q <= left_q - chunk_len;
    end
  end

  assign chunk_len  = pick_min(left_q, MAX_L);
  assign chunk_addr = base_q + off_q;
  assign seg_empty  = (left_q == '0);

  // R3
  take_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (left_q <= $past(remain)) && (left_q <= $past(seg_len)));

  // R2
  chunk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load) |=> chunk_addr == $past(chunk_addr) + 32'($past(chunk_len)));

endmodule

// File: rtl/dcg_word_emitter.sv
module dcg_word_emitter
  import desc_chain_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      cfg_word,
  input  logic [31:0]      size_word,
  input  logic [31:0]      addr_word,
  input  logic [31:0]      next_word,
  output logic             wr_en,
  output logic [IDX_W+1:0] wr_addr,
  output logic [31:0]      wr_data,
  output logic             desc_fin
);

  logic [1:0] w_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      w_q <= 2'd0;
    else if (active) w_q <= w_q + 2'd1;
  end

  always_comb begin
    unique case (dcg_word_e'(w_q))
      W_CFG:   wr_data = cfg_word;
      W_SIZE:  wr_data = size_word;
      W_ADDR:  wr_data = addr_word;
      default: wr_data = next_word;
    endcase
  end

  assign wr_en    = active;
  assign wr_addr  = {idx, w_q};
  assign desc_fin = active && (w_q == 2'd3);

  // R8
  word_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[1:0] != 2'd0) |-> $past(wr_en) && (wr_addr == $past(wr_addr) + 1'b1));

endmodule

// File: rtl/desc_chain_gen.sv
module desc_chain_gen
  import desc_chain_pkg::*;
#(
  parameter  int unsigned NUM_DESC  = 64,
  parameter  int unsigned MAX_CHUNK = 4096,
  parameter  int unsigned LEN_W     = 24,
  localparam int unsigned IDX_W     = $clog2(NUM_DESC),
  localparam int unsigned CNT_W     = IDX_W + 1,
  localparam int unsigned WA_W      = IDX_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] total_len,
  input  logic [31:0]      table_base,
  input  logic             seg_valid,
  output logic             seg_ready,
  input  logic [31:0]      seg_addr,
  input  logic [LEN_W-1:0] seg_len,
  output logic             wr_en,
  output logic [WA_W-1:0]  wr_addr,
  output logic [31:0]      wr_data,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic [CNT_W-1:0] desc_count
);

  dcg_state_e       state_q;
  logic [LEN_W-1:0] remain_q;
  logic [CNT_W-1:0] idx_q;
  logic [31:0]      base_q;
  logic             done_q, err_q;
  logic [CNT_W-1:0] cnt_q;

  // internal events
  logic             seg_take;
  logic             emit_active;
  logic             desc_fin;
  logic             last_desc;
  logic             table_full_next;
  logic             seg_empty;
  logic [LEN_W-1:0] chunk_len;
  logic [31:0]      chunk_addr;
  logic [31:0]      cfg_w, next_w;

  assign seg_ready       = (state_q == DCG_FETCH);
  assign seg_take        = seg_ready && seg_valid;
  assign emit_active     = (state_q == DCG_EMIT) && !seg_empty;
  assign last_desc       = (chunk_len == remain_q);
  assign table_full_next = (idx_q == CNT_W'(NUM_DESC - 1));
  assign cfg_w           = dcg_cfg(idx_q == '0, last_desc);
  assign next_w          = dcg_next(base_q, 32'(idx_q), last_desc);

  dcg_seg_slicer #(.LEN_W(LEN_W), .MAX_CHUNK(MAX_CHUNK)) u_slicer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (seg_take),
    .advance    (desc_fin),
    .seg_addr   (seg_addr),
    .seg_len    (seg_len),
    .remain     (remain_q),
    .chunk_len  (chunk_len),
    .chunk_addr (chunk_addr),
    .seg_empty  (seg_empty)
  );

  dcg_word_emitter #(.IDX_W(IDX_W)) u_emit (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (emit_active),
    .idx       (idx_q[IDX_W-1:0]),
    .cfg_word  (cfg_w),
    .size_word (32'(chunk_len)),
    .addr_word (chunk_addr),
    .next_word (next_w),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .desc_fin  (desc_fin)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= DCG_IDLE;
      remain_q <= '0;
      idx_q    <= '0;
      base_q   <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      cnt_q    <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        DCG_IDLE: begin
          if (start) begin
            cnt_q <= '0;
            if (total_len == '0) begin
              done_q <= 1'b1;
            end else begin
              remain_q <= total_len;
              idx_q    <= '0;
              base_q   <= table_base;
              state_q  <= DCG_FETCH;
            end
          end
        end
        DCG_FETCH: begin
          if (seg_valid) state_q <= DCG_EMIT;
        end
        DCG_EMIT: begin
          if (seg_empty) begin
            state_q <= DCG_FETCH;
          end else if (desc_fin) begin
            remain_q <= remain_q - chunk_len;
            idx_q    <= idx_q + 1'b1;
            if (last_desc) begin
              done_q  <= 1'b1;
              cnt_q   <= idx_q + 1'b1;
              state_q <= DCG_IDLE;
            end else if (table_full_next) begin
              err_q   <= 1'b1;
              cnt_q   <= idx_q + 1'b1;
              state_q <= DCG_IDLE;
            end
          end
        end
        default: state_q <= DCG_IDLE;
      endcase
    end
  end

  assign busy       = (state_q != DCG_IDLE);
  assign done       = done_q;
  assign error      = err_q;
  assign desc_count = cnt_q;

  // R9
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  // R12
  idle_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |-> !busy && !seg_ready);

  // R10
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (idx_q < CNT_W'(NUM_DESC)));

  // R11
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && total_len == '0) |=> done && desc_count == '0 && !wr_en);

  // R6
  last_ends_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_fin && last_desc) |=> done && !busy);

endmodule

// File: tb/sim_desc_chain_gen.sv
module sim_desc_chain_gen;

  localparam int ND = 4;
  localparam int MC = 16;
  localparam int LW = 12;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [LW-1:0] total_len = '0;
  logic [31:0]   table_base = '0;
  logic          seg_valid = 1'b0;
  logic          seg_ready;
  logic [31:0]   seg_addr = '0;
  logic [LW-1:0] seg_len = '0;
  logic          wr_en;
  logic [IW+1:0] wr_addr;
  logic [31:0]   wr_data;
  logic          busy, done, error;
  logic [IW:0]   desc_count;

  always #2 clk = ~clk;

  desc_chain_gen #(.NUM_DESC(ND), .MAX_CHUNK(MC), .LEN_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .total_len(total_len),
    .table_base(table_base), .seg_valid(seg_valid), .seg_ready(seg_ready),
    .seg_addr(seg_addr), .seg_len(seg_len), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .done(done), .error(error),
    .desc_count(desc_count)
  );

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] mem [ND*4];
  logic [31:0] sa [4];
  int          sl [4];
  logic [31:0] e_size [ND];
  logic [31:0] e_addr [ND];
  bit          e_last [ND];

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_case(input int nseg, input logic [31:0] base,
                          input int total, input bit poke);
    int n, rem, take, off, c, si, cyc, post, writes, acc, dn, er;
    bit ovf, acc_prev;
    logic [IW:0] cnt;
    logic [31:0] cfg;
    for (int k = 0; k < ND*4; k++) mem[k] = 32'hDEADBEEF;
    // arithmetic model of the chain
    n = 0; rem = total;
    for (int s = 0; s < nseg; s++) begin
      take = (sl[s] < rem) ? sl[s] : rem;
      off = 0;
      while (take > 0 && n < ND) begin
        c = (take < MC) ? take : MC;
        e_size[n] = 32'(c);
        e_addr[n] = sa[s] + 32'(off);
        rem -= c; take -= c; off += c;
        e_last[n] = (rem == 0);
        n++;
      end
    end
    ovf = (rem > 0);
    // drive
    writes = 0; acc = 0; dn = 0; er = 0; cnt = '0;
    @(negedge clk);
    table_base = base; total_len = LW'(total); start = 1'b1;
    si = 0; seg_valid = (nseg > 0); seg_addr = sa[0]; seg_len = LW'(sl[0]);
    acc_prev = seg_valid && seg_ready;
    cyc = 0; post = -1;
    while (post != 0 && cyc < 400) begin
      @(negedge clk); cyc++;
      start = poke && (cyc == 6);
      total_len = (poke && cyc == 6) ? LW'(total + 3) : LW'(total);
      if (wr_en) begin mem[wr_addr] = wr_data; writes++; end
      if (done)  begin dn++; cnt = desc_count; end
      if (error) begin er++; cnt = desc_count; end
      if (acc_prev) begin
        acc++; si++;
        if (si < nseg) begin seg_addr = sa[si]; seg_len = LW'(sl[si]); end
        else seg_valid = 1'b0;
      end
      acc_prev = seg_valid && seg_ready;
      if (post > 0) post--;
      else if (post < 0 && (done || error)) post = 3;
    end
    seg_valid = 1'b0; start = 1'b0;
    if (cyc >= 400) chk("R9", "run watchdog", 32'(cyc), 32'd0);
    if (ovf) begin
      chk("R10", "error pulses", 32'(er), 32'd1);
      chk("R10", "done pulses on overflow", 32'(dn), 32'd0);
      chk("R10", "count on overflow", 32'(cnt), 32'(ND));
    end else begin
      chk("R9", "done pulses", 32'(dn), 32'd1);
      chk("R9", "error pulses", 32'(er), 32'd0);
      chk("R9", "count", 32'(cnt), 32'(n));
    end
    chk("R8", "write total", 32'(writes), 32'(4*n));
    if (total == 0) chk("R11", "segments taken", 32'(acc), 32'd0);
    if (n < ND) chk("R8", "slot after chain untouched", mem[4*n], 32'hDEADBEEF);
    for (int i = 0; i < n; i++) begin
      cfg = mem[4*i];
      chk("R4", "own+chain bits", cfg & 32'h8000_0010, 32'h8000_0010);
      chk("R5", "first bit", 32'(cfg[3]), 32'(i == 0));
      if (e_last[i]) begin
        chk("R6", "last+ring bits", cfg & 32'h26, 32'h24);
        chk("R6", "next ptr", mem[4*i+3], 32'd0);
      end else begin
        chk("R7", "noirq bit", cfg & 32'h26, 32'h02);
        chk("R7", "next ptr", mem[4*i+3], base + 32'((i+1)*16));
      end
      chk("R2", "size", mem[4*i+1], e_size[i]);
      chk("R3", "buffer addr", mem[4*i+2], e_addr[i]);
    end
    if (poke) chk("R12", "busy start ignored, count", 32'(cnt), ovf ? 32'(ND) : 32'(n));
  endtask

  initial begin
    #(4*190000);
    chk("R9", "global watchdog", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "busy", 32'(busy), 32'd0);
    chk("R1", "done", 32'(done), 32'd0);
    chk("R1", "error", 32'(error), 32'd0);
    chk("R1", "seg_ready", 32'(seg_ready), 32'd0);
    chk("R1", "wr_en", 32'(wr_en), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle after release", 32'(busy), 32'd0);

    // set A: mixed lengths with an empty segment
    sa[0] = 32'h100; sa[1] = 32'h200; sa[2] = 32'h300; sa[3] = 32'h400;
    sl[0] = 5; sl[1] = 0; sl[2] = 20; sl[3] = 40;
    for (int t = 0; t <= 65; t++)
      run_case(4, 32'h1000 + 32'(t*64), t, (t % 7 == 3) && t > 16);

    // set B: one long segment, wrapping table base
    sa[0] = 32'h0000_A000; sl[0] = 64;
    for (int t = 1; t <= 64; t++)
      run_case(1, (t % 2 == 1) ? 32'hFFFF_FFD0 : 32'h0002_0000, t, t == 40);

    // set C: exact-size segments
    sa[0] = 32'h10; sa[1] = 32'h50; sa[2] = 32'h90; sa[3] = 32'hD0;
    sl[0] = 16; sl[1] = 16; sl[2] = 16; sl[3] = 16;
    run_case(4, 32'h4000, 64, 1'b0);
    run_case(4, 32'h4000, 48, 1'b1);
    sl[0] = 17; sl[1] = 50;
    run_case(2, 32'h4400, 17, 1'b0);
    run_case(2, 32'h4400, 67, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule